// File: doc/BRIEF.md
# Debug Trigger Mode Controller

This block sits beside a set of bus comparators in a debug subsystem and decides when a capture session has reached its trigger point. It receives single-cycle match pulses from two address comparators (A and B) and from a third comparator (C). It also takes an address-in-range indication and an event-qualifier strobe. A 4-bit mode field selects how these inputs combine into one trigger. The modes cover a single match, either of two matches, two matches in sequence, matches on the same cycle, a match that excludes another, qualified events, and windows inside or outside an address range.

Each comparator also leaves a sticky flag behind. The flags and the mode field can be read through one 8-bit status word. A narrow write port loads the mode, and every write clears the flags. A separate arm pulse starts a new session: it clears the flags, clears the trigger and clears the sequence history. The trigger output stays high once it fires, until the next arm pulse.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After a cycle with rst_n low, the status word reads 0x00 and trig_fired is low.
- R2: The status word is {flag A (bit 7), flag B (bit 6), flag C (bit 5), 0 (bit 4), mode (bits 3:0)}. Bit 4 always reads 0. A cycle with reg_wr_en high loads reg_wr_mode into bits 3:0 from the next cycle on. The mode holds when no write is made.
- R3: While the unit is armed, a match on A, B or C sets its flag from the following cycle on. The flag then stays set until it is cleared.
- R4: Before the first arm pulse, matches and range or event inputs set no flag and do not raise trig_fired. An arm pulse clears all three flags and trig_fired on the next cycle, and it also discards any earlier A match for the sequential modes.
- R5: A write cycle clears all three flags on the next cycle, whatever mode value is written. The clear wins over a match in that same cycle.
- R6: Mode 0 fires on an A match, mode 1 on an A or a B match, mode 5 on A and B in the same cycle, and mode 6 on A without B in the same cycle.
- R7: Mode 2 fires on a B match only when an A match occurred in an earlier cycle of the current session. A B match before or together with the first A match does not fire. A register write does not erase the A history.
- R8: Mode 3 fires on a B match in a cycle with the event qualifier high. Mode 4 also requires an A match in an earlier cycle of the session.
- R9: Mode 7 fires in any armed cycle with addr_in_range high. Mode 8 fires in any armed cycle with it low.
- R10: Mode values 9 to 15 behave exactly as mode 0.
- R11: trig_fired rises one cycle after the firing input cycle. It then stays high through register writes and idle cycles until the next arm pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Status/control write strobe; loads the mode and clears the flags |
| reg_wr_mode | input | 4 | Mode value written with reg_wr_en |
| arm_pulse | input | 1 | Starts a new session; clears the flags, the trigger and the A history |
| match_a | input | 1 | Comparator A match in this cycle |
| match_b | input | 1 | Comparator B match in this cycle |
| match_c | input | 1 | Comparator C match in this cycle |
| event_qual | input | 1 | Event qualifier for the event-only modes |
| addr_in_range | input | 1 | Bus address lies between the A and B addresses, inclusive |
| reg_rd_data | output | 8 | Status word: flags, reserved zero, mode |
| trig_fired | output | 1 | Trigger has fired in this session |

## Verification
The hardest situation to reach is a sequential mode where the A history and the flags disagree. This happens when a register write after an A match clears flag A but has to leave the sequence state intact, so that a later B still fires. A directed sequence builds this case: arm, then A, then a write, then B. The sweep goes through every mode value, including the reserved ones. For each mode it applies every pair of consecutive 5-bit input patterns after an arm, so every ordering of A before, with or after B is reached. It also covers every qualifier and range combination around them. A model in the bench computes the expected trigger and status word for each pair.

// File: rtl/dbg_trig_pkg.sv
// Package: shared widths, status-word bit positions and mode codes for the
// debug trigger controller. Assumes a 4-bit mode field in an 8-bit word.
package dbg_trig_pkg;
    localparam int MODE_W    = 4;
    localparam int NUM_CMP   = 3;
    localparam int STAT_W    = NUM_CMP + 1 + MODE_W;
    localparam int FLAG_A_IX = STAT_W - 1;
    localparam int FLAG_B_IX = STAT_W - 2;
    localparam int FLAG_C_IX = STAT_W - 3;
    localparam int RSVD_IX   = MODE_W;

    typedef enum logic [MODE_W-1:0] {
        TM_A_ONLY       = 4'd0,
        TM_A_OR_B       = 4'd1,
        TM_A_THEN_B     = 4'd2,
        TM_EVT_B        = 4'd3,
        TM_A_THEN_EVT_B = 4'd4,
        TM_A_AND_B      = 4'd5,
        TM_A_NOT_B      = 4'd6,
        TM_IN_RANGE     = 4'd7,
        TM_OUT_RANGE    = 4'd8
    } trig_mode_e;
endpackage

// File: rtl/dbg_flag_bank.sv
// Sticky match flags, one per comparator. A flag is set by its hit while
// armed and is cleared by the clear strobe, which wins over a hit in the
// same cycle. Assumes hits are one-cycle qualified pulses.
module dbg_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         armed,
    input  logic [N-1:0] hit,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold or update one sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n)              flags[i] <= 1'b0;
            else if (clear)          flags[i] <= 1'b0;
            else if (armed && hit[i]) flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/dbg_seq_tracker.sv
// Remembers whether comparator A has matched earlier in the current session.
// Only a new session (restart) forgets it; register writes do not.
module dbg_seq_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic armed,
    input  logic hit_a,
    output logic a_seen
);
    // Record the first A match since the session started.
    always_ff @(posedge clk) begin
        if (!rst_n)               a_seen <= 1'b0;
        else if (restart)         a_seen <= 1'b0;
        else if (armed && hit_a)  a_seen <= 1'b1;
    end
endmodule

// File: rtl/dbg_mode_eval.sv
// Combinational trigger condition for the selected mode. It assumes a_seen
// reflects earlier cycles only. Unlisted mode codes fall back to A only.
module dbg_mode_eval
    import dbg_trig_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic              evt,
    input  logic              in_range,
    input  logic              a_seen,
    output logic              fire_cond
);
    // Map the mode code to its trigger condition.
    always_comb begin
        case (mode)
            TM_A_OR_B:       fire_cond = hit_a | hit_b;
            TM_A_THEN_B:     fire_cond = a_seen & hit_b;
            TM_EVT_B:        fire_cond = hit_b & evt;
            TM_A_THEN_EVT_B: fire_cond = a_seen & hit_b & evt;
            TM_A_AND_B:      fire_cond = hit_a & hit_b;
            TM_A_NOT_B:      fire_cond = hit_a & ~hit_b;
            TM_IN_RANGE:     fire_cond = in_range;
            TM_OUT_RANGE:    fire_cond = ~in_range;
            default:         fire_cond = hit_a;
        endcase
    end
endmodule

// File: rtl/dbg_trigger_unit.sv
// Top of the debug trigger controller. It holds the mode field, the armed
// state and the sticky trigger, and it assembles the status word. It assumes
// the match, event and range inputs are synchronous to clk, one cycle each.
module dbg_trigger_unit
    import dbg_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [MODE_W-1:0] reg_wr_mode,
    input  logic              arm_pulse,
    input  logic              match_a,
    input  logic              match_b,
    input  logic              match_c,
    input  logic              event_qual,
    input  logic              addr_in_range,
    output logic [STAT_W-1:0] reg_rd_data,
    output logic              trig_fired
);
    logic [MODE_W-1:0]  mode_q;
    logic               armed_q;
    logic               fired_q;
    logic               a_seen;
    logic               fire_cond;
    logic [NUM_CMP-1:0] flags;

    // Mode field: loaded by a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (reg_wr_en) mode_q <= reg_wr_mode;
    end

    // Armed state: set by the first arm pulse and kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (arm_pulse) armed_q <= 1'b1;
    end

    // Sticky trigger: set by the mode condition and cleared by arming.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fired_q <= 1'b0;
        else if (arm_pulse)             fired_q <= 1'b0;
        else if (armed_q && fire_cond)  fired_q <= 1'b1;
    end

    dbg_flag_bank #(.N(NUM_CMP)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (arm_pulse | reg_wr_en),
        .armed (armed_q),
        .hit   ({match_a, match_b, match_c}),
        .flags (flags)
    );

    dbg_seq_tracker i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (arm_pulse),
        .armed   (armed_q),
        .hit_a   (match_a),
        .a_seen  (a_seen)
    );

    dbg_mode_eval i_eval (
        .mode      (mode_q),
        .hit_a     (match_a),
        .hit_b     (match_b),
        .evt       (event_qual),
        .in_range  (addr_in_range),
        .a_seen    (a_seen),
        .fire_cond (fire_cond)
    );

    assign reg_rd_data = {flags, 1'b0, mode_q};
    assign trig_fired  = fired_q;
endmodule

// File: rtl/dbg_trigger_checker.sv
// Port-level properties of the debug trigger controller, bound to its top.
module dbg_trigger_checker
    import dbg_trig_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [MODE_W-1:0] reg_wr_mode,
    input logic              arm_pulse,
    input logic              match_a,
    input logic [STAT_W-1:0] reg_rd_data,
    input logic              trig_fired
);
    logic ever_armed;

    // Track whether any arm pulse has been seen since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         ever_armed <= 1'b0;
        else if (arm_pulse) ever_armed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_rd_data == '0 && !trig_fired));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[RSVD_IX] == 1'b0);

    p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data[MODE_W-1:0] == $past(reg_wr_mode));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_en |=> $stable(reg_rd_data[MODE_W-1:0]));

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[FLAG_A_IX] && !reg_wr_en && !arm_pulse) |=> reg_rd_data[FLAG_A_IX]);

    p_flag_a_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ever_armed && match_a && !reg_wr_en && !arm_pulse) |=> reg_rd_data[FLAG_A_IX]);

    p_unarmed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ever_armed && !arm_pulse) |=> (reg_rd_data[FLAG_A_IX:FLAG_C_IX] == '0 && !trig_fired));

    p_arm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_pulse |=> (reg_rd_data[FLAG_A_IX:FLAG_C_IX] == '0 && !trig_fired));

    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data[FLAG_A_IX:FLAG_C_IX] == '0);

    p_fire_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_fired && !arm_pulse) |=> trig_fired);
endmodule

bind dbg_trigger_unit dbg_trigger_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_mode (reg_wr_mode),
    .arm_pulse   (arm_pulse),
    .match_a     (match_a),
    .reg_rd_data (reg_rd_data),
    .trig_fired  (trig_fired)
);

// File: tb/test_dbg_trigger_unit.sv
module test_dbg_trigger_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_en;
    logic [3:0] reg_wr_mode;
    logic       arm_pulse;
    logic       match_a, match_b, match_c, event_qual, addr_in_range;
    logic [7:0] reg_rd_data;
    logic       trig_fired;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    dbg_trigger_unit i_dbg_trigger_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_mode(reg_wr_mode),
        .arm_pulse(arm_pulse), .match_a(match_a), .match_b(match_b), .match_c(match_c),
        .event_qual(event_qual), .addr_in_range(addr_in_range),
        .reg_rd_data(reg_rd_data), .trig_fired(trig_fired)
    );

    // Drive one cycle of inputs (p: bit0 A, bit1 B, bit2 C, bit3 event, bit4 range).
    task automatic cyc(input logic wr, input logic [3:0] md, input logic arm, input logic [4:0] p);
        reg_wr_en = wr; reg_wr_mode = md; arm_pulse = arm;
        match_a = p[0]; match_b = p[1]; match_c = p[2]; event_qual = p[3]; addr_in_range = p[4];
        @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s trig actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic fire_f(int m, logic a, logic b, logic e, logic r, logic seen);
        case (m)
            1: return a | b;
            2: return seen & b;
            3: return b & e;
            4: return seen & b & e;
            5: return a & b;
            6: return a & ~b;
            7: return r;
            8: return ~r;
            default: return a;
        endcase
    endfunction

    function automatic string req_of(int m);
        case (m)
            0, 1, 5, 6: return "R6";
            2:          return "R7";
            3, 4:       return "R8";
            7, 8:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cyc(1'b0, 4'h0, 1'b0, 5'h1f);
        cyc(1'b0, 4'h0, 1'b0, 5'h1f);
        chk8("R1", reg_rd_data, 8'h00);
        chk1("R1", trig_fired, 1'b0);
        rst_n = 1'b1;

        // R4: not yet armed, all inputs active, range low
        cyc(1'b0, 4'h0, 1'b0, 5'h0f);
        cyc(1'b0, 4'h8, 1'b0, 5'h00);
        chk8("R4", reg_rd_data, 8'h00);
        chk1("R4", trig_fired, 1'b0);
        // R2: mode 15 read back, bit 4 zero
        cyc(1'b1, 4'hf, 1'b0, 5'h00);
        chk8("R2", reg_rd_data, 8'h0f);
        cyc(1'b0, 4'h3, 1'b0, 5'h00);
        chk8("R2", reg_rd_data, 8'h0f);

        // R3 / R11: mode 0, A match, then idle cycles
        cyc(1'b1, 4'h0, 1'b0, 5'h00);
        cyc(1'b0, 4'h0, 1'b1, 5'h00);
        cyc(1'b0, 4'h0, 1'b0, 5'h01);
        chk1("R11", trig_fired, 1'b1);
        cyc(1'b0, 4'h0, 1'b0, 5'h00);
        cyc(1'b0, 4'h0, 1'b0, 5'h00);
        chk8("R3", reg_rd_data, 8'h80);
        // R5: write with simultaneous B and C match clears; R11 trigger holds
        cyc(1'b1, 4'h0, 1'b0, 5'h06);
        chk8("R5", reg_rd_data, 8'h00);
        chk1("R11", trig_fired, 1'b1);
        // R4: arm clears the trigger
        cyc(1'b0, 4'h0, 1'b1, 5'h00);
        chk1("R4", trig_fired, 1'b0);

        // R7: A history survives a write that clears flag A
        cyc(1'b1, 4'h2, 1'b0, 5'h00);
        cyc(1'b0, 4'h0, 1'b1, 5'h00);
        cyc(1'b0, 4'h0, 1'b0, 5'h01);
        cyc(1'b1, 4'h2, 1'b0, 5'h00);
        chk1("R7", trig_fired, 1'b0);
        cyc(1'b0, 4'h0, 1'b0, 5'h02);
        chk1("R7", trig_fired, 1'b1);
        chk8("R7", reg_rd_data, 8'h42);
        // R4: arm discards the A history
        cyc(1'b0, 4'h0, 1'b1, 5'h00);
        cyc(1'b0, 4'h0, 1'b0, 5'h02);
        chk1("R4", trig_fired, 1'b0);

        // Sweep: every mode, every pair of consecutive input patterns
        for (int m = 0; m < 16; m++) begin
            for (int p1 = 0; p1 < 32; p1++) begin
                for (int p2 = 0; p2 < 32; p2++) begin
                    logic [4:0] a1, a2;
                    logic       ef;
                    logic [7:0] es;
                    a1 = 5'(p1); a2 = 5'(p2);
                    cyc(1'b1, 4'(m), 1'b0, 5'h00);
                    cyc(1'b0, 4'h0, 1'b1, 5'h00);
                    cyc(1'b0, 4'h0, 1'b0, a1);
                    cyc(1'b0, 4'h0, 1'b0, a2);
                    ef = fire_f(m, a1[0], a1[1], a1[3], a1[4], 1'b0)
                       | fire_f(m, a2[0], a2[1], a2[3], a2[4], a1[0]);
                    es = {a1[0] | a2[0], a1[1] | a2[1], a1[2] | a2[2], 1'b0, 4'(m)};
                    chk1(req_of(m), trig_fired, ef);
                    chk8("R3", reg_rd_data, es);
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule